// File: doc/BRIEF.md
# Decimator Clock Source Generator

This block produces the working clocks of one decimator channel. Everything runs in a single system-clock domain, and every clock is modelled as a strobe that is high for one cycle. A 3-bit source code picks one of several strobes: three divider outputs, two analog-column clocks, the system clock, or one shared digital row output. A separate 4-bit row select chooses that row output from sixteen candidates. From the chosen source the block makes a base strobe. It also makes a chain of phase strobes at half, quarter and finer rates.

When the channel takes its data from the analog comparator, the generator is bypassed. In that mode every output follows the column clock. Clearing the channel enable silences all outputs. A configuration write pulse restarts the phase counter, so the divided strobes line up with the write.

Top module: `dclk_srcgen`

## Requirements
- R1: Source code 000 selects divider strobe bit 0, 001 selects bit 1, 100 selects bit 2, 010 selects analog clock bit 0, 011 selects analog clock bit 1, and 110 selects the system clock, which is high every cycle.
- R2: Source code 111 is reserved and never produces a strobe on any output.
- R3: Source code 101 selects `row_out[row_sel]`, where `row_sel` is the 4-bit index of the shared row output.
- R4: `clk_base` is a registered copy of the selected source strobe. It is high one cycle after the source strobe it follows.
- R5: `clk_div[0]` fires together with `clk_base` on every second source strobe counted since the last restart.
- R6: `clk_div[k]` fires on every 2^(k+1)-th source strobe since the last restart. `clk_div[1]` therefore marks every fourth strobe, and it only fires when `clk_div[0]` also fires.
- R7: A cycle with `cfg_wr` high restarts the phase counter from zero and discards any strobe in that cycle. All outputs are low in the following cycle, and the first `clk_div[0]` comes on the second strobe after the write.
- R8: While `chan_en` is low, all outputs are low one cycle later whatever the source code is, and the phase counter is held at zero.
- R9: While `cmp_bypass` is high and the channel is enabled, `clk_base` and every `clk_div` bit equal `cmp_clk` delayed by one cycle, and the phase counter is held at zero.
- R10: While `rst` is high, all outputs are low at the next edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| chan_en | input | 1 | Channel enable |
| cmp_bypass | input | 1 | Comparator is the data input; bypass the generator |
| cmp_clk | input | 1 | Clock strobe from the analog column, used in bypass |
| cfg_wr | input | 1 | Pulse marking a write to any clock configuration field |
| src_sel | input | 3 | Source code |
| row_sel | input | 4 | Shared row output index |
| div_stb | input | 3 | Divider strobes |
| ana_clk | input | 2 | Analog-column clock strobes |
| row_out | input | 16 | Digital row primary outputs |
| clk_base | output | 1 | Base strobe at the source rate |
| clk_div | output | 2 | Divided phase strobes; bit k runs at source/2^(k+1) |

## Verification
A phase counter in the wrong state shows up at the ports as a divided strobe on the wrong source strobe. The bench makes this visible within four strobes after a restart, a disable or a bypass period. It does so by comparing the exact strobe count at which `clk_div` first fires against a write placed mid-stream. A wrong source mapping or row index shows up on `clk_base` in the very next cycle. The stimulus drives the wanted source and all the unwanted sources in opposite states.

// File: rtl/dclk_pkg.sv
package dclk_pkg;

    localparam int unsigned N_DIV_SRC = 3;
    localparam int unsigned N_ANA_SRC = 2;

    typedef enum logic [2:0] {
        SRC_DIV_A = 3'b000,
        SRC_DIV_B = 3'b001,
        SRC_ANA_0 = 3'b010,
        SRC_ANA_1 = 3'b011,
        SRC_DIV_C = 3'b100,
        SRC_ROW   = 3'b101,
        SRC_SYS   = 3'b110,
        SRC_NONE  = 3'b111
    } src_code_e;

    typedef struct packed {
        logic [N_DIV_SRC-1:0] div;
        logic [N_ANA_SRC-1:0] ana;
        logic                 row;
        logic                 sys;
    } src_bus_t;

    function automatic logic pick_source(src_code_e code, src_bus_t b);
        logic s;
        case (code)
            SRC_DIV_A: s = b.div[0];
            SRC_DIV_B: s = b.div[1];
            SRC_DIV_C: s = b.div[2];
            SRC_ANA_0: s = b.ana[0];
            SRC_ANA_1: s = b.ana[1];
            SRC_ROW:   s = b.row;
            SRC_SYS:   s = b.sys;
            default:   s = 1'b0;
        endcase
        return s;
    endfunction

endpackage

// File: rtl/dclk_row_pick.sv
module dclk_row_pick #(
    parameter int unsigned ROW_W = 16,
    localparam int unsigned SEL_W = $clog2(ROW_W)
) (
    input  logic [ROW_W-1:0] row_out,
    input  logic [SEL_W-1:0] row_sel,
    output logic             row_stb
);
    always_comb begin
        row_stb = row_out[row_sel];
    end
endmodule

// File: rtl/dclk_src_mux.sv
module dclk_src_mux
    import dclk_pkg::*;
(
    input  logic [2:0] src_sel,
    input  src_bus_t   srcs,
    output logic       src_stb
);
    src_code_e code;

    always_comb begin
        code    = src_code_e'(src_sel);
        src_stb = pick_source(code, srcs);
    end
endmodule

// File: rtl/dclk_phase_div.sv
module dclk_phase_div #(
    parameter int unsigned N_STAGES = 2
) (
    input  logic                clk,
    input  logic                rst,
    input  logic                clr,
    input  logic                stb,
    output logic [N_STAGES-1:0] phase
);
    logic [N_STAGES-1:0] cnt;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            cnt <= '0;
        end else if (stb) begin
            cnt <= cnt + 1'b1;
        end
    end

    for (genvar k = 0; k < N_STAGES; k++) begin : g_stage
        assign phase[k] = stb & (&cnt[k:0]);
    end
endmodule

// File: rtl/dclk_srcgen.sv
module dclk_srcgen
    import dclk_pkg::*;
#(
    parameter int unsigned ROW_W    = 16,
    parameter int unsigned N_STAGES = 2,
    localparam int unsigned SEL_W   = $clog2(ROW_W)
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 chan_en,
    input  logic                 cmp_bypass,
    input  logic                 cmp_clk,
    input  logic                 cfg_wr,
    input  logic [2:0]           src_sel,
    input  logic [SEL_W-1:0]     row_sel,
    input  logic [N_DIV_SRC-1:0] div_stb,
    input  logic [N_ANA_SRC-1:0] ana_clk,
    input  logic [ROW_W-1:0]     row_out,
    output logic                 clk_base,
    output logic [N_STAGES-1:0]  clk_div
);
    logic                row_stb;
    logic                src_stb;
    logic                hold;
    logic                cnt_stb;
    logic [N_STAGES-1:0] phase;
    src_bus_t            srcs;

    dclk_row_pick #(.ROW_W(ROW_W)) row_i (
        .row_out (row_out),
        .row_sel (row_sel),
        .row_stb (row_stb)
    );

    always_comb begin
        srcs.div = div_stb;
        srcs.ana = ana_clk;
        srcs.row = row_stb;
        srcs.sys = 1'b1;
    end

    dclk_src_mux mux_i (
        .src_sel (src_sel),
        .srcs    (srcs),
        .src_stb (src_stb)
    );

    // The counter is held while the channel is idle, bypassed or being reconfigured.
    assign hold    = cfg_wr | ~chan_en | cmp_bypass;
    assign cnt_stb = src_stb & ~hold;

    dclk_phase_div #(.N_STAGES(N_STAGES)) div_i (
        .clk   (clk),
        .rst   (rst),
        .clr   (hold),
        .stb   (cnt_stb),
        .phase (phase)
    );

    always_ff @(posedge clk) begin
        if (rst || cfg_wr || !chan_en) begin
            clk_base <= 1'b0;
            clk_div  <= '0;
        end else if (cmp_bypass) begin
            clk_base <= cmp_clk;
            clk_div  <= {N_STAGES{cmp_clk}};
        end else begin
            clk_base <= cnt_stb;
            clk_div  <= phase;
        end
    end
endmodule

// File: rtl/dclk_srcgen_chk.sv
module dclk_srcgen_chk #(
    parameter int unsigned ROW_W    = 16,
    parameter int unsigned N_STAGES = 2
) (
    input logic                clk,
    input logic                rst,
    input logic                chan_en,
    input logic                cmp_bypass,
    input logic                cmp_clk,
    input logic                cfg_wr,
    input logic [2:0]          src_sel,
    input logic [ROW_W-1:0]    row_out,
    input logic                clk_base,
    input logic [N_STAGES-1:0] clk_div
);
    assert_idle_silent_R8: assert property (@(posedge clk) disable iff (rst)
        !chan_en |=> (!clk_base && clk_div == '0));

    assert_write_blanks_R7: assert property (@(posedge clk) disable iff (rst)
        cfg_wr |=> (!clk_base && clk_div == '0));

    assert_bypass_follows_R9: assert property (@(posedge clk) disable iff (rst)
        (chan_en && cmp_bypass && !cfg_wr) |=>
            (clk_base == $past(cmp_clk) && clk_div == {N_STAGES{$past(cmp_clk)}}));

    assert_reserved_quiet_R2: assert property (@(posedge clk) disable iff (rst)
        (chan_en && !cmp_bypass && !cfg_wr && src_sel == 3'b111) |=> !clk_base);

    assert_half_with_base_R5: assert property (@(posedge clk) disable iff (rst)
        clk_div[0] |-> clk_base);

    for (genvar k = 1; k < N_STAGES; k++) begin : g_nest
        assert_nested_phase_R6: assert property (@(posedge clk) disable iff (rst)
            clk_div[k] |-> clk_div[k-1]);
    end

    logic unused_ok;
    assign unused_ok = ^row_out;
endmodule

bind dclk_srcgen dclk_srcgen_chk #(.ROW_W(ROW_W), .N_STAGES(N_STAGES)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .chan_en    (chan_en),
    .cmp_bypass (cmp_bypass),
    .cmp_clk    (cmp_clk),
    .cfg_wr     (cfg_wr),
    .src_sel    (src_sel),
    .row_out    (row_out),
    .clk_base   (clk_base),
    .clk_div    (clk_div)
);

// File: tb/dclk_srcgen_tb_top.sv
module dclk_srcgen_tb_top;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        en = 1'b0, byp = 1'b0, cmp = 1'b0, cfg = 1'b0;
    logic [2:0]  sel = 3'b110;
    logic [3:0]  rsel = 4'h0;
    logic [2:0]  dv = 3'b000;
    logic [1:0]  an = 2'b00;
    logic [15:0] rw = 16'h0000;
    logic        clk_base;
    logic [1:0]  clk_div;

    int n_chk = 0;
    int n_bad = 0;
    bit done = 1'b0;

    always #2 clk = ~clk;

    dclk_srcgen dut_i (
        .clk(clk), .rst(rst), .chan_en(en), .cmp_bypass(byp), .cmp_clk(cmp),
        .cfg_wr(cfg), .src_sel(sel), .row_sel(rsel), .div_stb(dv),
        .ana_clk(an), .row_out(rw), .clk_base(clk_base), .clk_div(clk_div)
    );

    // {sel, rsel, div, ana, row, expected clk_base}
    localparam int NV = 14;
    localparam logic [28:0] VEC [NV] = '{
        {3'b000, 4'h0, 3'b001, 2'b00, 16'h0000, 1'b1}, // R1
        {3'b000, 4'h0, 3'b110, 2'b11, 16'hFFFF, 1'b0}, // R1
        {3'b001, 4'h0, 3'b010, 2'b00, 16'h0000, 1'b1}, // R1
        {3'b001, 4'h0, 3'b101, 2'b11, 16'hFFFF, 1'b0}, // R1
        {3'b010, 4'h0, 3'b000, 2'b01, 16'h0000, 1'b1}, // R1
        {3'b010, 4'h0, 3'b111, 2'b10, 16'hFFFF, 1'b0}, // R1
        {3'b011, 4'h0, 3'b000, 2'b10, 16'h0000, 1'b1}, // R1
        {3'b100, 4'h0, 3'b100, 2'b00, 16'h0000, 1'b1}, // R1
        {3'b100, 4'h0, 3'b011, 2'b11, 16'hFFFF, 1'b0}, // R1
        {3'b101, 4'h5, 3'b000, 2'b00, 16'h0020, 1'b1}, // R3
        {3'b101, 4'h5, 3'b111, 2'b11, 16'hFFDF, 1'b0}, // R3
        {3'b101, 4'hF, 3'b000, 2'b00, 16'h8000, 1'b1}, // R3
        {3'b110, 4'h0, 3'b000, 2'b00, 16'h0000, 1'b1}, // R1
        {3'b111, 4'h0, 3'b111, 2'b11, 16'hFFFF, 1'b0}  // R2
    };

    task automatic tick();
        @(posedge clk);
        #1;
    endtask

    // exp = {clk_div[1], clk_div[0], clk_base}
    task automatic chk(string req, logic [2:0] exp);
        n_chk++;
        if ({clk_div, clk_base} !== exp) begin
            n_bad++;
            $display("FAIL %s: got %b expected %b", req, {clk_div, clk_base}, exp);
        end
    endtask

    task automatic restart();
        cfg = 1'b1; tick(); chk("R7", 3'b000); cfg = 1'b0;
    endtask

    initial begin
        // R10: reset state
        rst = 1'b1; en = 1'b1; sel = 3'b110;
        tick(); chk("R10", 3'b000);
        tick(); chk("R10", 3'b000);
        rst = 1'b0;

        // R1 R2 R3: source table, base strobe only
        for (int i = 0; i < NV; i++) begin
            {sel, rsel, dv, an, rw} = VEC[i][28:1];
            tick();
            n_chk++;
            if (clk_base !== VEC[i][0]) begin
                n_bad++;
                $display("FAIL R1/R2/R3 vec %0d: got %b expected %b", i, clk_base, VEC[i][0]);
            end
        end
        dv = 3'b000; an = 2'b00; rw = 16'h0000;

        // R2: reserved code produces nothing on any output
        sel = 3'b111; restart();
        for (int i = 0; i < 5; i++) begin tick(); chk("R2", 3'b000); end

        // R4 R5 R6: continuous system clock after restart
        sel = 3'b110; restart();
        for (int i = 1; i <= 8; i++) begin
            tick();
            chk("R6", {(i % 4 == 0), (i % 2 == 0), 1'b1});
        end

        // R7: mid-stream realignment with a divider source
        sel = 3'b000; restart();
        for (int i = 1; i <= 3; i++) begin
            dv = 3'b001; tick(); chk("R5", {1'b0, (i == 2), 1'b1});
            dv = 3'b000; tick(); chk("R4", 3'b000);
        end
        dv = 3'b001; cfg = 1'b1; tick(); chk("R7", 3'b000); cfg = 1'b0;
        tick(); chk("R7", 3'b001);
        tick(); chk("R7", 3'b011);
        tick(); chk("R7", 3'b001);
        tick(); chk("R7", 3'b111);
        dv = 3'b000;

        // R8: disable forces zero and clears the count
        sel = 3'b110; restart();
        tick(); chk("R8", 3'b001);
        en = 1'b0;
        for (int i = 0; i < 3; i++) begin tick(); chk("R8", 3'b000); end
        en = 1'b1;
        tick(); chk("R8", 3'b001);
        tick(); chk("R8", 3'b011);

        // R9: bypass follows the column clock
        restart();
        tick(); chk("R9", 3'b001);
        byp = 1'b1;
        cmp = 1'b1; tick(); chk("R9", 3'b111);
        cmp = 1'b0; tick(); chk("R9", 3'b000);
        cmp = 1'b1; tick(); chk("R9", 3'b111);
        tick(); chk("R9", 3'b111);
        en = 1'b0; tick(); chk("R8", 3'b000);
        en = 1'b1; byp = 1'b0; cmp = 1'b0;
        tick(); chk("R9", 3'b001);
        tick(); chk("R9", 3'b011);

        done = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
        $finish;
    end

    initial begin
        repeat (20000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL watchdog: got timeout expected completion");
            $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
            $finish;
        end
    end
endmodule